// File: doc/BRIEF.md
# Cache Victim Way Selector

This block decides which way of a set-associative cache set gets overwritten when a lookup misses. The cache controller pulses a miss strobe together with the valid bits of the addressed set. The block then registers a victim way index and raises a victim-valid flag, and both hold until the controller either allocates the line or abandons the fill.

The choice follows a fixed priority. An empty (invalid) way is always taken first. When every way is full, a mode input selects the source. One source is a single global round-robin counter shared by all sets. The other is the low bits of a free-running linear feedback shift register (LFSR). The choice is made when the miss is seen. The counter moves on only when a line it nominated is actually allocated, so a fill that is abandoned or served from an empty way leaves the rotation where it was.

Top module: `repl_victim_sel`

## Requirements
- R1: While reset is held and in the cycle after it is released, `vic_vld_o` is 0. After reset the round-robin counter is 0 and the LFSR holds 16'hACE1.
- R2: If the set presented with an accepted miss has any way with its valid bit at 0, the victim is the lowest-numbered such way, in either mode.
- R3: With all four ways valid and `rand_mode_i` = 0, the victim equals the round-robin counter.
- R4: An allocation that releases a victim that came from the counter advances the counter by one, wrapping from 3 to 0.
- R5: An allocation that releases a victim chosen as an empty way, or in random mode, leaves the counter unchanged.
- R6: With all ways valid and `rand_mode_i` = 1, the victim is bits [1:0] of the LFSR as held at the miss edge. The LFSR shifts left every clock and takes in bit 0 the XOR of bits 15, 13, 12 and 10.
- R7: While a victim is held and neither `alloc_i` nor `cancel_i` is high, `vic_o` and `vic_vld_o` do not change, and any miss is ignored.
- R8: `cancel_i` alone drops `vic_vld_o` on the next edge and leaves the counter unchanged.
- R9: `alloc_i` or `cancel_i` with no victim held has no effect.
- R10: A miss in the same cycle as an allocation or cancel of the held victim is accepted. If that allocation advances the counter, the new victim sees the advanced value.
- R11: `alloc_i` and `cancel_i` high together are treated as an allocation.
- R12: `vic_o` and `vic_vld_o` are registered and update on the clock edge that samples the accepted miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_i | input | 1 | Lookup miss strobe |
| way_valid_i | input | 4 | Valid bits of the addressed set, bit n for way n |
| alloc_i | input | 1 | Line allocated into the held victim way |
| cancel_i | input | 1 | Abandon the pending fill |
| rand_mode_i | input | 1 | 0 selects round-robin, 1 selects LFSR-based replacement |
| vic_o | output | 2 | Victim way index |
| vic_vld_o | output | 1 | Victim index held and valid |

## Verification
A new miss and the release of the held victim can land in the same cycle. This is the case where the counter must advance and also feed the new choice at once. The bench provokes it with directed miss-plus-allocate cycles around the 3-to-0 wrap and through a long seeded random phase that asserts miss, allocate and cancel independently. A reference model in the bench applies the release first and the capture second, and the index that comes out is compared with the model after every edge.

// File: rtl/repl_pkg.sv
// Package: shared types for the victim way selector.
// Assumes: nothing beyond IEEE 1800-2017.
package repl_pkg;
    // Source used when every way of the set is full.
    typedef enum logic {
        REPL_ROUND  = 1'b0,
        REPL_RANDOM = 1'b1
    } repl_mode_e;
endpackage

// File: rtl/repl_lfsr.sv
// Module: free-running Fibonacci LFSR used as a pseudo-random way source.
// Assumes: TAPS describes a maximal-length polynomial and SEED is non-zero.
module repl_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state_o
);
    logic fb;

    // Feedback bit is the parity of the tapped positions.
    always_comb fb = ^(state_o & TAPS);

    // Shift every clock; reload the seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_o <= SEED;
        else        state_o <= {state_o[W-2:0], fb};
    end

    p_lfsr_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != '0)
        else $error("LFSR reached the all-zero lock state");
endmodule

// File: rtl/repl_rr_ctr.sv
// Module: global round-robin victim counter.
// Assumes: adv_i is high for at most one cycle per allocation.
// cnt_fwd_o shows the value the counter holds after this edge.
module repl_rr_ctr #(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    output logic [IDX_W-1:0] cnt_o,
    output logic [IDX_W-1:0] cnt_fwd_o
);
    // Forward the advanced value so a same-cycle miss sees it.
    always_comb cnt_fwd_o = cnt_o + IDX_W'(adv_i);

    // Hold or step the counter, wrapping naturally at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_o <= '0;
        else        cnt_o <= cnt_fwd_o;
    end

    p_ctr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> cnt_o == IDX_W'($past(cnt_o) + 1'b1))
        else $error("counter did not step on allocation");

    p_ctr_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(cnt_o))
        else $error("counter moved without allocation");
endmodule

// File: rtl/repl_first_invalid.sv
// Module: finds the lowest-numbered way whose valid bit is clear.
// Assumes: idx_o is meaningful only while any_inv_o is high.
module repl_first_invalid #(
    parameter int WAYS  = 4,
    parameter int IDX_W = 2
) (
    input  logic [WAYS-1:0]  valid_i,
    output logic             any_inv_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan from the top down so the lowest empty way wins.
    always_comb begin
        idx_o = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid_i[i]) idx_o = i[IDX_W-1:0];
        end
        any_inv_o = ~&valid_i;
    end

    // R2: the picked way is empty and every way below it is full.
    always_comb begin
        if (!$isunknown(valid_i) && any_inv_o) begin
            p_pick_lowest_r2: assert (!valid_i[idx_o] &&
                ((valid_i & ((WAYS'(1) << idx_o) - WAYS'(1))) ==
                 ((WAYS'(1) << idx_o) - WAYS'(1))))
                else $error("empty-way pick is not the lowest empty way");
        end
    end
endmodule

// File: rtl/repl_victim_sel.sv
// Module: victim way selector for a set-associative cache.
// Captures a victim on an accepted miss and holds it until allocation
// or cancel. Empty ways win, then round-robin counter or LFSR by mode.
// Assumes: WAYS is a power of two no wider than the LFSR.
module repl_victim_sel
    import repl_pkg::*;
#(
    parameter int          WAYS   = 4,
    parameter int          LFSR_W = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
    localparam int         IDX_W  = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_i,
    input  logic [WAYS-1:0]  way_valid_i,
    input  logic             alloc_i,
    input  logic             cancel_i,
    input  logic             rand_mode_i,
    output logic [IDX_W-1:0] vic_o,
    output logic             vic_vld_o
);
    logic [LFSR_W-1:0] lfsr;
    logic [IDX_W-1:0]  cnt, cnt_fwd, inv_idx, pick;
    logic              any_inv, from_ctr_q, pick_ctr;
    logic              release_w, adv, miss_acc;
    repl_mode_e        mode;

    repl_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .state_o(lfsr)
    );

    repl_rr_ctr #(.IDX_W(IDX_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .adv_i(adv),
        .cnt_o(cnt), .cnt_fwd_o(cnt_fwd)
    );

    repl_first_invalid #(.WAYS(WAYS), .IDX_W(IDX_W)) u_inv (
        .valid_i(way_valid_i), .any_inv_o(any_inv), .idx_o(inv_idx)
    );

    // Release and acceptance terms; allocation outranks cancel.
    always_comb begin
        mode      = repl_mode_e'(rand_mode_i);
        release_w = vic_vld_o && (alloc_i || cancel_i);
        adv       = vic_vld_o && alloc_i && from_ctr_q;
        miss_acc  = miss_i && (!vic_vld_o || release_w);
    end

    // Victim choice: empty way, else LFSR or forwarded counter.
    always_comb begin
        pick_ctr = 1'b0;
        if (any_inv) begin
            pick = inv_idx;
        end else if (mode == REPL_RANDOM) begin
            pick = lfsr[IDX_W-1:0];
        end else begin
            pick     = cnt_fwd;
            pick_ctr = 1'b1;
        end
    end

    // Hold register for the victim, its valid flag and its source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vic_o      <= '0;
            vic_vld_o  <= 1'b0;
            from_ctr_q <= 1'b0;
        end else if (miss_acc) begin
            vic_o      <= pick;
            vic_vld_o  <= 1'b1;
            from_ctr_q <= pick_ctr;
        end else if (release_w) begin
            vic_vld_o  <= 1'b0;
            from_ctr_q <= 1'b0;
        end
    end

    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vic_vld_o && !alloc_i && !cancel_i |=> vic_vld_o && $stable(vic_o))
        else $error("held victim changed without release");

    p_cancel_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vic_vld_o && cancel_i && !miss_i |=> !vic_vld_o)
        else $error("cancel did not drop the victim");

    p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !vic_vld_o && !miss_i |=> !vic_vld_o)
        else $error("victim appeared without a miss");

    p_miss_capture_r12: assert property (@(posedge clk) disable iff (!rst_n)
        miss_i && !vic_vld_o |=> vic_vld_o)
        else $error("miss not captured on the next edge");
endmodule

// File: tb/repl_victim_sel_tb.sv
module repl_victim_sel_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       miss = 1'b0, alloc = 1'b0, cancel = 1'b0, rmode = 1'b0;
    logic [3:0] valid = 4'hF;
    logic [1:0] vic;
    logic       vld;
    int         total = 0, bad = 0;

    // Reference state, built from the requirements.
    logic        m_vld, m_ctr_src;
    logic [1:0]  m_vic, m_cnt;
    logic [15:0] m_lfsr;

    always #2 clk = ~clk;

    repl_victim_sel u_dut (
        .clk(clk), .rst_n(rst_n), .miss_i(miss), .way_valid_i(valid),
        .alloc_i(alloc), .cancel_i(cancel), .rand_mode_i(rmode),
        .vic_o(vic), .vic_vld_o(vld)
    );

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic [1:0] low_empty(input logic [3:0] v);
        for (int i = 0; i < 4; i++) if (!v[i]) return 2'(i);
        return 2'd0;
    endfunction

    // Model update on each edge: release first, then capture.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_vld = 0; m_cnt = 0; m_lfsr = 16'hACE1; m_ctr_src = 0; m_vic = 0;
        end else begin
            logic rel, adv, acc;
            logic [1:0] ncnt;
            rel  = m_vld && (alloc || cancel);
            adv  = m_vld && alloc && m_ctr_src;
            acc  = miss && (!m_vld || rel);
            ncnt = m_cnt + 2'(adv);
            if (acc) begin
                m_vld = 1;
                if (valid != 4'hF) begin m_vic = low_empty(valid); m_ctr_src = 0; end
                else if (rmode)    begin m_vic = m_lfsr[1:0];      m_ctr_src = 0; end
                else               begin m_vic = ncnt;             m_ctr_src = 1; end
            end else if (rel) begin
                m_vld = 0; m_ctr_src = 0;
            end
            m_cnt  = ncnt;
            m_lfsr = lfsr_next(m_lfsr);
        end
    end

    task automatic check(input string tag);
        total++;
        if (vld !== m_vld || (m_vld && vic !== m_vic)) begin
            bad++;
            $display("FAIL %s: vld=%0b vic=%0d expected vld=%0b vic=%0d",
                     tag, vld, vic, m_vld, m_vic);
        end
    endtask

    // Drive one cycle at the falling edge, check at the next falling edge.
    task automatic step(input logic mi, input logic [3:0] v, input logic al,
                        input logic ca, input logic rm, input string tag);
        miss = mi; valid = v; alloc = al; cancel = ca; rmode = rm;
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");
        // R3 / R12: first round-robin miss yields the reset counter value 0
        step(1, 4'hF, 0, 0, 0, "R3");
        step(1, 4'h0, 0, 0, 0, "R7");      // held; new miss ignored
        step(0, 4'hF, 1, 0, 0, "R4");      // allocate, counter -> 1
        for (int k = 0; k < 4; k++) begin  // walk through the wrap
            step(1, 4'hF, 0, 0, 0, "R4");
            step(0, 4'hF, 1, 0, 0, "R4");
        end
        // R2: empty ways win in both modes; R5: no counter step
        step(1, 4'b1010, 0, 0, 0, "R2");
        step(0, 4'hF, 1, 0, 0, "R5");
        step(1, 4'b0011, 0, 0, 1, "R2");
        step(0, 4'hF, 1, 0, 0, "R5");
        step(1, 4'hF, 0, 0, 0, "R5");
        step(0, 4'hF, 0, 1, 0, "R8");      // cancel, counter kept
        step(1, 4'hF, 0, 0, 0, "R8");
        step(0, 4'hF, 1, 0, 0, "R4");
        // R6: LFSR-sourced picks
        for (int k = 0; k < 6; k++) begin
            step(1, 4'hF, 0, 0, 1, "R6");
            step(0, 4'hF, 1, 0, 1, "R5");
        end
        // R9: release strobes while idle
        step(0, 4'hF, 1, 0, 0, "R9");
        step(0, 4'hF, 0, 1, 0, "R9");
        step(1, 4'hF, 0, 0, 0, "R9");
        // R10: miss with releasing allocation sees advanced counter
        step(1, 4'hF, 1, 0, 0, "R10");
        step(1, 4'hF, 1, 0, 0, "R10");
        step(1, 4'hF, 0, 1, 0, "R10");
        // R11: allocate and cancel together behave as allocate
        step(0, 4'hF, 1, 1, 0, "R11");
        step(1, 4'hF, 0, 0, 0, "R11");
        step(0, 4'hF, 1, 0, 0, "R11");
        // Seeded random mix of all strobes
        void'($urandom(32'd7));
        for (int k = 0; k < 3000; k++) begin
            logic [3:0] v;
            v = ($urandom % 3 == 0) ? 4'($urandom) : 4'hF;
            step(1'($urandom % 2), v, 1'($urandom % 3 == 0),
                 1'($urandom % 7 == 0), 1'($urandom % 2), "R12");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: expired=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule